// File: doc/BRIEF.md
# Decrementer Timer with Interrupt Request

This block pairs a down-counting decrementer with a free-running 64-bit time base. Both advance on a single shared tick enable, so they never drift apart. A processor core can overwrite the decrementer through a write-enable and data port, and can read the decrementer and both 32-bit halves of the time base at any time. Reads are plain combinational views of the registers, so a read cannot change the count.

The block drives one interrupt request line. In edge mode, a 0-to-1 change of the decrementer's top bit sets a pending request. The change may come from counting, from the wrap below zero, or from a software write. Any number of such changes before the core responds collapse into a single pending request, and one acknowledge pulse clears it. In level mode, the request simply mirrors the top bit, and it drops only when the top bit returns to 0. The mode input is static and should be changed only while reset is held.

Top module: `dec_timer`

## Requirements
- R1: While reset is held and after it is released, the time base reads 0, the decrementer reads 0xFFFFFFFF, and in edge mode the request is low.
- R2: Each cycle with tick high decreases the decrementer by one and increases the time base by one, in the same cycle. A cycle without tick leaves both unchanged.
- R3: A tick taken while the decrementer is 0 wraps it to 0xFFFFFFFF. Because bit 31 goes from 0 to 1, in edge mode this raises the request on the cycle the wrapped value appears.
- R4: A write replaces all 32 bits of the decrementer with the written data. When a write and a tick fall in the same cycle, the written value is loaded with no decrement, while the time base still advances.
- R5: In edge mode, a write that changes bit 31 from 0 to 1 raises the request. A write that leaves bit 31 at 1 raises nothing.
- R6: In edge mode, several 0-to-1 changes of bit 31 before an acknowledge leave a single pending request, and one acknowledge clears it.
- R7: In edge mode, an acknowledge clears the pending request on the next cycle. An acknowledge with nothing pending has no effect.
- R8: In edge mode, when an acknowledge and a new 0-to-1 change of bit 31 fall in the same cycle, the request stays pending.
- R9: In level mode (mode = 1), the request equals bit 31 of the decrementer. The acknowledge does not clear it. Writing a value with bit 31 = 0 drops it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Shared count enable for decrementer and time base |
| irq_mode | input | 1 | 0 = edge (pending and coalesced), 1 = level (follows bit 31) |
| dec_we | input | 1 | Decrementer write enable |
| dec_wdata | input | 32 | Decrementer write data |
| dec_rdata | output | 32 | Current decrementer value |
| tb_hi_rdata | output | 32 | Upper half of the time base |
| tb_lo_rdata | output | 32 | Lower half of the time base |
| irq_req | output | 1 | Interrupt request to the core |
| irq_ack | input | 1 | Marks the interrupt as taken |

## Verification
The bench drives the wrap through zero and checks the cycle on which the request appears. A design that only watched counting transitions, or compared against the old value one cycle late, would show the request missing or delayed. It collides a write with a tick: a wrong priority would load the written value minus one. It also collides an acknowledge with a fresh wrap, where a design that favoured the acknowledge would lose an interrupt. It piles up two wraps before one acknowledge, where a counter in place of a flag would leave a stray request. In level mode, it checks that an acknowledge leaves the request high and that only a positive write lowers it.

// File: rtl/dec_timer_pkg.sv
package dec_timer_pkg;

    typedef enum logic {
        IRQ_EDGE  = 1'b0,
        IRQ_LEVEL = 1'b1
    } irq_mode_e;

    // Top-bit status reported by the decrementer to the request logic.
    typedef struct packed {
        logic rise;   // bit 31 goes 0 -> 1 at this edge
        logic msb;    // current bit 31
    } msb_evt_t;

    function automatic logic msb_rise(input logic old_msb, input logic new_msb);
        return (!old_msb) && new_msb;
    endfunction

endpackage

// File: rtl/dec_time_base.sv
module dec_time_base #(
    parameter int TB_W = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    output logic [TB_W-1:0] tb_value
);
    logic [TB_W-1:0] tb_q;

    always_ff @(posedge clk) begin
        if (rst)       tb_q <= '0;
        else if (tick) tb_q <= tb_q + 1'b1;
    end

    assign tb_value = tb_q;

    a_r2_tb_step: assert property (@(posedge clk) disable iff (rst)
        tick |=> (tb_q == $past(tb_q) + 1'b1));
    a_r2_tb_hold: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(tb_q));
endmodule

// File: rtl/dec_down_counter.sv
module dec_down_counter
    import dec_timer_pkg::*;
#(
    parameter int DEC_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             we,
    input  logic [DEC_W-1:0] wdata,
    output logic [DEC_W-1:0] count,
    output msb_evt_t         evt
);
    localparam int MSB = DEC_W - 1;

    logic [DEC_W-1:0] cnt_q, cnt_d;

    // Write wins over a tick in the same cycle.
    always_comb begin
        cnt_d = cnt_q;
        if (we)        cnt_d = wdata;
        else if (tick) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '1;
        else     cnt_q <= cnt_d;
    end

    assign count    = cnt_q;
    assign evt.rise = msb_rise(cnt_q[MSB], cnt_d[MSB]);
    assign evt.msb  = cnt_q[MSB];

    a_r4_write_loads: assert property (@(posedge clk) disable iff (rst)
        we |=> (cnt_q == $past(wdata)));
    a_r2_tick_decrements: assert property (@(posedge clk) disable iff (rst)
        (tick && !we) |=> (cnt_q == $past(cnt_q) - 1'b1));
    a_r2_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (!tick && !we) |=> $stable(cnt_q));
endmodule

// File: rtl/dec_irq_gen.sv
module dec_irq_gen
    import dec_timer_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  irq_mode_e mode,
    input  msb_evt_t  evt,
    input  logic      ack,
    output logic      irq
);
    logic pend_q;

    // A new rise beats a same-cycle acknowledge; repeated rises coalesce.
    always_ff @(posedge clk) begin
        if (rst)           pend_q <= 1'b0;
        else if (evt.rise) pend_q <= 1'b1;
        else if (ack)      pend_q <= 1'b0;
    end

    always_comb begin
        unique case (mode)
            IRQ_LEVEL: irq = evt.msb;
            default:   irq = pend_q;
        endcase
    end

    a_r5_rise_sets: assert property (@(posedge clk) disable iff (rst)
        evt.rise |=> pend_q);
    a_r7_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (ack && !evt.rise) |=> !pend_q);
    a_r6_no_spurious: assert property (@(posedge clk) disable iff (rst)
        (!evt.rise && !pend_q) |=> !pend_q);
endmodule

// File: rtl/dec_timer.sv
module dec_timer
    import dec_timer_pkg::*;
#(
    parameter int DEC_W = 32,
    parameter int TB_W  = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic               irq_mode,
    input  logic               dec_we,
    input  logic [DEC_W-1:0]   dec_wdata,
    output logic [DEC_W-1:0]   dec_rdata,
    output logic [TB_W/2-1:0]  tb_hi_rdata,
    output logic [TB_W/2-1:0]  tb_lo_rdata,
    output logic               irq_req,
    input  logic               irq_ack
);
    localparam int HALF = TB_W / 2;

    logic [TB_W-1:0] tb_value;
    msb_evt_t        evt;
    irq_mode_e       mode;

    assign mode = irq_mode_e'(irq_mode);

    dec_time_base #(.TB_W(TB_W)) u_tb (
        .clk(clk), .rst(rst), .tick(tick), .tb_value(tb_value)
    );

    dec_down_counter #(.DEC_W(DEC_W)) u_dec (
        .clk(clk), .rst(rst), .tick(tick), .we(dec_we),
        .wdata(dec_wdata), .count(dec_rdata), .evt(evt)
    );

    dec_irq_gen u_irq (
        .clk(clk), .rst(rst), .mode(mode), .evt(evt),
        .ack(irq_ack), .irq(irq_req)
    );

    assign tb_hi_rdata = tb_value[TB_W-1:HALF];
    assign tb_lo_rdata = tb_value[HALF-1:0];

    a_r9_level_tracks_msb: assert property (@(posedge clk) disable iff (rst)
        (mode == IRQ_LEVEL) |-> (irq_req == dec_rdata[DEC_W-1]));
    a_r8_rise_survives_ack: assert property (@(posedge clk) disable iff (rst)
        (mode == IRQ_EDGE && irq_ack && evt.rise) |=> irq_req);
endmodule

// File: tb/dec_timer_bench.sv
module dec_timer_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        irq_mode = 1'b0;
    logic        dec_we = 1'b0;
    logic [31:0] dec_wdata = '0;
    logic [31:0] dec_rdata, tb_hi_rdata, tb_lo_rdata;
    logic        irq_req;
    logic        irq_ack = 1'b0;

    int checks = 0;
    int failures = 0;
    longint tb_exp = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dec_timer u_dec_timer (
        .clk(clk), .rst(rst), .tick(tick), .irq_mode(irq_mode),
        .dec_we(dec_we), .dec_wdata(dec_wdata), .dec_rdata(dec_rdata),
        .tb_hi_rdata(tb_hi_rdata), .tb_lo_rdata(tb_lo_rdata),
        .irq_req(irq_req), .irq_ack(irq_ack)
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // One clock: apply inputs at the falling edge, sample at the next falling edge.
    task automatic cyc(input bit t, input bit we, input logic [31:0] wd, input bit ack);
        tick = t; dec_we = we; dec_wdata = wd; irq_ack = ack;
        @(posedge clk);
        if (t) tb_exp++;
        @(negedge clk);
        tick = 1'b0; dec_we = 1'b0; irq_ack = 1'b0;
    endtask

    task automatic do_reset(input bit mode);
        @(negedge clk);
        rst = 1'b1; irq_mode = mode;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        tb_exp = 0;
    endtask

    task automatic t_reset();
        do_reset(1'b0);
        check("R1 dec", dec_rdata, 32'hFFFF_FFFF);
        check("R1 tb_lo", tb_lo_rdata, 0);
        check("R1 tb_hi", tb_hi_rdata, 0);
        check("R1 irq", irq_req, 0);
    endtask

    task automatic t_count();
        for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0);
        check("R2 dec after 3 ticks", dec_rdata, 32'hFFFF_FFFC);
        check("R2 tb after 3 ticks", {tb_hi_rdata, tb_lo_rdata}, tb_exp);
        cyc(0, 0, 0, 0);
        cyc(0, 0, 0, 0);
        check("R2 dec hold", dec_rdata, 32'hFFFF_FFFC);
        check("R2 tb hold", tb_lo_rdata, 3);
        check("R2 irq quiet", irq_req, 0);
    endtask

    task automatic t_write_priority();
        cyc(1, 1, 32'h0000_0010, 0);
        check("R4 write beats tick", dec_rdata, 32'h0000_0010);
        check("R4 tb still ticks", {tb_hi_rdata, tb_lo_rdata}, tb_exp);
        cyc(0, 1, 32'h1234_5678, 0);
        check("R4 full replace", dec_rdata, 32'h1234_5678);
    endtask

    task automatic t_wrap();
        cyc(0, 1, 32'h1, 0);
        cyc(1, 0, 0, 0);
        check("R3 reach zero", dec_rdata, 0);
        check("R3 no irq at zero", irq_req, 0);
        cyc(1, 0, 0, 0);
        check("R3 wrap value", dec_rdata, 32'hFFFF_FFFF);
        check("R3 wrap raises irq", irq_req, 1);
        cyc(0, 0, 0, 1);
        check("R7 ack clears", irq_req, 0);
        cyc(0, 0, 0, 1);
        check("R7 ack when idle", irq_req, 0);
    endtask

    task automatic t_write_rise();
        cyc(0, 1, 32'h0000_0100, 0);
        check("R5 positive write quiet", irq_req, 0);
        cyc(0, 1, 32'h8000_0005, 0);
        check("R5 write 0->1 raises", irq_req, 1);
        cyc(0, 0, 0, 1);
        check("R7 ack after write rise", irq_req, 0);
        cyc(0, 1, 32'hC000_0000, 0);
        check("R5 write 1->1 quiet", irq_req, 0);
    endtask

    task automatic t_coalesce();
        cyc(0, 1, 32'h0, 0);
        cyc(1, 0, 0, 0);
        check("R6 first rise", irq_req, 1);
        cyc(0, 1, 32'h0, 0);
        cyc(1, 0, 0, 0);
        check("R6 second rise pending", irq_req, 1);
        cyc(0, 0, 0, 1);
        check("R6 single ack clears all", irq_req, 0);
        cyc(0, 0, 0, 0);
        check("R6 no leftover", irq_req, 0);
    endtask

    task automatic t_ack_collide();
        cyc(0, 1, 32'h0, 0);
        cyc(1, 0, 0, 0);
        cyc(0, 1, 32'h0, 0);
        cyc(1, 0, 0, 1);
        check("R8 rise wins over ack", irq_req, 1);
        cyc(0, 0, 0, 1);
        check("R8 later ack clears", irq_req, 0);
    endtask

    task automatic t_level();
        do_reset(1'b1);
        check("R9 level after reset", irq_req, 1);
        cyc(0, 0, 0, 1);
        check("R9 ack ignored", irq_req, 1);
        cyc(0, 1, 32'h5, 0);
        check("R9 positive write drops", irq_req, 0);
        cyc(0, 1, 32'h0, 0);
        cyc(1, 0, 0, 0);
        check("R9 wrap raises level", irq_req, 1);
        cyc(1, 0, 0, 1);
        check("R9 still high after ack", irq_req, 1);
        cyc(0, 1, 32'h7, 0);
        check("R9 cleared by write", irq_req, 0);
    endtask

    initial begin
        t_reset();
        t_count();
        t_write_priority();
        t_wrap();
        t_write_rise();
        t_coalesce();
        t_ack_collide();
        t_level();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule